// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver Section

This block is one section of a bidirectional transceiver that sits between two buses, called the A port and the B port. Each transfer direction has its own storage register, its own capture clock, its own source select and its own output enable. The output path of each direction forwards one of two values: the live data from the opposite bus, or the value held in that direction's register. The block can therefore pass traffic straight through, hold a snapshot of either bus, or drive stored values back out. It can also isolate the two buses from each other.

Tri-state pads are modelled as a separate input vector, output vector and enable vector for each port. The whole section runs on one core clock. The two per-direction capture clocks arrive as ordinary level inputs. A capture happens at the first core clock edge at which a capture clock is seen high after being low. The value captured is the port's resolved bus value. If the port is driving, that is its own output. If it is not driving, that is the external input. A port that is driving stored data can therefore copy that value into the other direction's register.

Top module: `regXcvrSection`

## Requirements
- R1: At the first core clock edge where `abCapClk` is sampled high after being sampled low, the A-to-B register loads the resolved A value. The new value is visible at `bOut` (with `abUseStore`=1) right after that edge and not before.
- R2: At the first core clock edge where `baCapClk` is sampled high after being sampled low, the B-to-A register loads the resolved B value. The new value is visible at `aOut` (with `baUseStore`=1) right after that edge.
- R3: `bOut` carries the A-to-B register when `abUseStore`=1. When `abUseStore`=0 it carries live A data. Live A data is `aIn`, except when the A port is driving stored data; in that case it is the driven value.
- R4: `aOut` carries the B-to-A register when `baUseStore`=1. When `baUseStore`=0 it carries live B data, which is `bIn` unless the B port is driving stored data.
- R5: Every bit of `bOe` is 1 when `abDriveEn`=1 (active high) and 0 when `abDriveEn`=0.
- R6: Every bit of `aOe` is 1 when `baDriveEnN`=0 (active low) and 0 when `baDriveEnN`=1.
- R7: The value captured from a port is its own output while that port is driving, and its external input otherwise.
- R8: With `abDriveEn`=0 and `baDriveEnN`=1, neither port drives. Capture edges in this state store `aIn` and `bIn` independently.
- R9: While the A port drives stored B-to-A data, an A-to-B capture loads that same value, so both registers hold it. The mirror case holds for the B port.
- R10: When both capture edges are seen at the same core clock edge, each register loads the resolved value from before that edge, including a value that is sourced from the other register.
- R11: A synchronous reset `rst` clears both registers to zero.
- R12: A capture clock held high over many core clock cycles causes one capture only. Registers do not change without a capture edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| abCapClk | input | 1 | A-to-B capture clock level |
| baCapClk | input | 1 | B-to-A capture clock level |
| abUseStore | input | 1 | 1: B output forwards stored data; 0: live A data |
| baUseStore | input | 1 | 1: A output forwards stored data; 0: live B data |
| abDriveEn | input | 1 | B port drive enable, active high |
| baDriveEnN | input | 1 | A port drive enable, active low |
| aIn | input | WIDTH | External value at the A pads |
| aOut | output | WIDTH | Value driven onto the A pads |
| aOe | output | WIDTH | Per-bit A pad drive enable |
| bIn | input | WIDTH | External value at the B pads |
| bOut | output | WIDTH | Value driven onto the B pads |
| bOe | output | WIDTH | Per-bit B pad drive enable |

## Verification
The two functions that can coincide are the A-to-B and B-to-A captures. They are most telling when one port is driving a stored value, because one register's new value then comes from the other register's old one. The bench preloads distinct patterns into both registers. It sets the A port to drive stored B-to-A data and raises both capture clocks before the same core clock edge. It then reads both registers out through the stored-data output paths. The A-to-B register must hold the old B-to-A value, and the B-to-A register must hold `bIn`; neither may hold a value taken after the edge.

// File: rtl/regXcvrPkg.sv
package regXcvrPkg;

  localparam int unsigned DEF_WIDTH = 9;

  // Strobes and decoded controls handed from control to datapath
  typedef struct packed {
    logic capAb;    // single-cycle capture strobe, A-to-B register
    logic capBa;    // single-cycle capture strobe, B-to-A register
    logic driveA;   // A port pads are driven
    logic driveB;   // B port pads are driven
    logic storeAb;  // B output forwards the A-to-B register
    logic storeBa;  // A output forwards the B-to-A register
  } xcvrCtl_t;

endpackage

// File: rtl/regXcvrCtrl.sv
module regXcvrCtrl
  import regXcvrPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     abCapClk,
  input  logic     baCapClk,
  input  logic     abUseStore,
  input  logic     baUseStore,
  input  logic     abDriveEn,
  input  logic     baDriveEnN,
  output xcvrCtl_t ctl
);

  logic abClkQ;
  logic baClkQ;

  // During reset the history follows the level, so a clock already high
  // at reset release does not count as an edge.
  always_ff @(posedge clk) begin
    abClkQ <= abCapClk;
    baClkQ <= baCapClk;
  end

  always_comb begin
    ctl.capAb   = !rst && abCapClk && !abClkQ;
    ctl.capBa   = !rst && baCapClk && !baClkQ;
    ctl.driveB  = abDriveEn;
    ctl.driveA  = !baDriveEnN;
    ctl.storeAb = abUseStore;
    ctl.storeBa = baUseStore;
  end

  // R12: a level held high yields one strobe only
  a_r12_single_strobe_ab: assert property (@(posedge clk) disable iff (rst)
    ctl.capAb |=> !ctl.capAb);
  a_r12_single_strobe_ba: assert property (@(posedge clk) disable iff (rst)
    ctl.capBa |=> !ctl.capBa);

endmodule

// File: rtl/regXcvrDatapath.sv
module regXcvrDatapath
  import regXcvrPkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  xcvrCtl_t         ctl,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] aOe,
  output logic [WIDTH-1:0] bOe
);

  logic [WIDTH-1:0] regAb;
  logic [WIDTH-1:0] regBa;
  logic [WIDTH-1:0] aLive;   // value seen on A for forwarding
  logic [WIDTH-1:0] bLive;   // value seen on B for forwarding
  logic [WIDTH-1:0] aRes;    // resolved A bus value for capture
  logic [WIDTH-1:0] bRes;    // resolved B bus value for capture

  // Live paths never read the opposite live path, so no loop can form.
  always_comb begin
    aLive = (ctl.driveA && ctl.storeBa) ? regBa : aIn;
    bLive = (ctl.driveB && ctl.storeAb) ? regAb : bIn;
    bOut  = ctl.storeAb ? regAb : aLive;
    aOut  = ctl.storeBa ? regBa : bLive;
    aRes  = ctl.driveA ? aOut : aIn;
    bRes  = ctl.driveB ? bOut : bIn;
    aOe   = {WIDTH{ctl.driveA}};
    bOe   = {WIDTH{ctl.driveB}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regAb <= '0;
      regBa <= '0;
    end else begin
      if (ctl.capAb) regAb <= aRes;
      if (ctl.capBa) regBa <= bRes;
    end
  end

  // R12: registers move only on a capture strobe
  a_r12_hold_ab: assert property (@(posedge clk) disable iff (rst)
    !ctl.capAb |=> $stable(regAb));
  a_r12_hold_ba: assert property (@(posedge clk) disable iff (rst)
    !ctl.capBa |=> $stable(regBa));

endmodule

// File: rtl/regXcvrSection.sv
module regXcvrSection
  import regXcvrPkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abCapClk,
  input  logic             baCapClk,
  input  logic             abUseStore,
  input  logic             baUseStore,
  input  logic             abDriveEn,
  input  logic             baDriveEnN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOe
);

  xcvrCtl_t ctl;

  regXcvrCtrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .abCapClk   (abCapClk),
    .baCapClk   (baCapClk),
    .abUseStore (abUseStore),
    .baUseStore (baUseStore),
    .abDriveEn  (abDriveEn),
    .baDriveEnN (baDriveEnN),
    .ctl        (ctl)
  );

  regXcvrDatapath #(.WIDTH(WIDTH)) dp_i (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ctl),
    .aIn  (aIn),
    .bIn  (bIn),
    .aOut (aOut),
    .bOut (bOut),
    .aOe  (aOe),
    .bOe  (bOe)
  );

  // R5 / R6: pad enables follow the enable pins with their polarities
  a_r5_b_enable: assert property (@(posedge clk) disable iff (rst)
    bOe == (abDriveEn ? {WIDTH{1'b1}} : {WIDTH{1'b0}}));
  a_r6_a_enable: assert property (@(posedge clk) disable iff (rst)
    aOe == (baDriveEnN ? {WIDTH{1'b0}} : {WIDTH{1'b1}}));

  // R3: live forwarding from an undriven A port
  a_r3_live_ab: assert property (@(posedge clk) disable iff (rst)
    (!abUseStore && baDriveEnN) |-> (bOut == aIn));

  // R1: capture from an undriven A port appears on the stored B path
  a_r1_capture_ab: assert property (@(posedge clk) disable iff (rst)
    ($rose(abCapClk) && baDriveEnN) |=> (!abUseStore || (bOut == $past(aIn))));

endmodule

// File: tb/regXcvrSection_tb.sv
module regXcvrSection_tb_top;

  localparam int W = 9;
  localparam int NROWS = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic abCapClk = 1'b0, baCapClk = 1'b0;
  logic abUseStore = 1'b0, baUseStore = 1'b0;
  logic abDriveEn = 1'b0, baDriveEnN = 1'b1;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, aOe, bOut, bOe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  regXcvrSection #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .abCapClk(abCapClk), .baCapClk(baCapClk),
    .abUseStore(abUseStore), .baUseStore(baUseStore),
    .abDriveEn(abDriveEn), .baDriveEnN(baDriveEnN),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  // Row: {abDriveEn, baDriveEnN, abUseStore, baUseStore, pulseAb, pulseBa,
  //       aIn, bIn, expected bOut, expected aOut}
  localparam logic [41:0] VEC [NROWS] = '{
    {6'b010011, 9'h0A5, 9'h15A, 9'h000, 9'h000},  // R8 isolated capture
    {6'b111000, 9'h1FF, 9'h000, 9'h0A5, 9'h000},  // R3 stored A
    {6'b110000, 9'h033, 9'h000, 9'h033, 9'h000},  // R3 live A
    {6'b000100, 9'h000, 9'h0F0, 9'h000, 9'h15A},  // R4 stored B
    {6'b000000, 9'h000, 9'h0F0, 9'h000, 9'h0F0},  // R4 live B
    {6'b000110, 9'h1C3, 9'h0F0, 9'h000, 9'h15A},  // R9 A drives stored, capture AB
    {6'b111000, 9'h000, 9'h000, 9'h15A, 9'h000},  // R9 both hold same value
    {6'b110001, 9'h0C7, 9'h111, 9'h0C7, 9'h000},  // R7 B drives live A, capture BA
    {6'b000100, 9'h000, 9'h000, 9'h000, 9'h0C7}   // R7 captured own output
  };

  function automatic string rowTag(int i);
    case (i)
      0: return "R8";
      1, 2: return "R3";
      3, 4: return "R4";
      5, 6: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setCtl(logic en, logic enN, logic sAb, logic sBa);
    abDriveEn = en; baDriveEnN = enN; abUseStore = sAb; baUseStore = sBa;
  endtask

  // Capture clock pulse spanning two core cycles; edge seen at the first
  task automatic pulse(logic pAb, logic pBa);
    abCapClk = pAb; baCapClk = pBa;
    @(posedge clk); #2;
    abCapClk = 1'b0; baCapClk = 1'b0;
    @(posedge clk); #2;
  endtask

  // Load known values into both registers through an isolated capture
  task automatic preload(logic [W-1:0] va, logic [W-1:0] vb);
    setCtl(1'b0, 1'b1, 1'b0, 1'b0);
    aIn = va; bIn = vb; #1;
    pulse(1'b1, 1'b1);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R11: reset state, both registers read back as zero
    setCtl(1'b1, 1'b0, 1'b1, 1'b1);
    aIn = 9'h1AA; bIn = 9'h155;
    #1;
    chk("R11 reset bOut", bOut, 9'h000);
    chk("R11 reset aOut", aOut, 9'h000);
    rst = 1'b0;
    @(posedge clk); #2;

    // R5 / R6: enable encodings
    for (int k = 0; k < 4; k++) begin
      abDriveEn = k[0]; baDriveEnN = k[1]; #1;
      chk("R5 bOe", bOe, k[0] ? 9'h1FF : 9'h000);
      chk("R6 aOe", aOe, k[1] ? 9'h000 : 9'h1FF);
    end

    // Table walk, starting from cleared registers
    for (int i = 0; i < NROWS; i++) begin
      logic [41:0] v;
      v = VEC[i];
      setCtl(v[41], v[40], v[39], v[38]);
      aIn = v[35:27]; bIn = v[26:18];
      #1;
      if (v[37] || v[36]) pulse(v[37], v[36]);
      #1;
      chk({rowTag(i), " bOe"}, bOe, {W{v[41]}});
      chk({rowTag(i), " aOe"}, aOe, {W{~v[40]}});
      if (v[41]) chk({rowTag(i), " bOut"}, bOut, v[17:9]);
      if (!v[40]) chk({rowTag(i), " aOut"}, aOut, v[8:0]);
    end

    // R1: capture timing, A-to-B
    preload(9'h011, 9'h022);
    setCtl(1'b1, 1'b1, 1'b1, 1'b0);
    aIn = 9'h0E4; #1;
    abCapClk = 1'b1; #1;
    chk("R1 before edge", bOut, 9'h011);
    @(posedge clk); #1;
    chk("R1 after edge", bOut, 9'h0E4);
    // R12: level held high, data changes, no further capture
    aIn = 9'h07B;
    repeat (5) @(posedge clk);
    #1;
    chk("R12 held high AB", bOut, 9'h0E4);
    abCapClk = 1'b0;
    @(posedge clk); #2;

    // R2: capture timing, B-to-A
    setCtl(1'b0, 1'b0, 1'b0, 1'b1);
    bIn = 9'h1D2; #1;
    baCapClk = 1'b1; #1;
    chk("R2 before edge", aOut, 9'h022);
    @(posedge clk); #1;
    chk("R2 after edge", aOut, 9'h1D2);
    bIn = 9'h000;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 held high BA", aOut, 9'h1D2);
    baCapClk = 1'b0;
    @(posedge clk); #2;

    // R3: live A taken from A's driven stored value when B forwards live
    preload(9'h0AA, 9'h133);
    setCtl(1'b1, 1'b0, 1'b0, 1'b1);
    aIn = 9'h005; #1;
    chk("R3 live of driven A", bOut, 9'h133);

    // R10: simultaneous captures while A drives stored B-to-A data
    preload(9'h066, 9'h199);
    setCtl(1'b0, 1'b0, 1'b0, 1'b1);
    aIn = 9'h1F0; bIn = 9'h04C; #1;
    pulse(1'b1, 1'b1);
    setCtl(1'b1, 1'b0, 1'b1, 1'b1); #1;
    chk("R10 AB got old BA", bOut, 9'h199);
    chk("R10 BA got bIn", aOut, 9'h04C);

    // R9 mirror: B drives stored A-to-B, BA capture copies it
    preload(9'h0D1, 9'h002);
    setCtl(1'b1, 1'b1, 1'b1, 1'b0);
    bIn = 9'h1FF; #1;
    pulse(1'b0, 1'b1);
    setCtl(1'b0, 1'b0, 1'b0, 1'b1); #1;
    chk("R9 mirror BA copy", aOut, 9'h0D1);

    // R11: synchronous reset mid-run
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
    setCtl(1'b1, 1'b0, 1'b1, 1'b1); #1;
    chk("R11 mid-run bOut", bOut, 9'h000);
    chk("R11 mid-run aOut", aOut, 9'h000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule